// File: doc/BRIEF.md
# Three-Phase Synchronous-Read MAC Cell

This block is a small multicycle processing cell whose four memories (program, scalar data, weights and stream operands) all return read data one clock after the address, in the manner of compiled SRAM macros. Every instruction takes three clocks that never overlap. In the first clock the program counter addresses program memory. In the second clock the operand addresses go out. In the third clock the execute unit commits the instruction. The output register of each memory serves as the instruction or operand latch. No architectural state moves between the clock that reads an operand and the clock that uses it, so the cell needs no forwarding and no stall logic.

A host loads programs and data, and inspects results, through a debug port. The port reads combinationally and accepts writes only while the cell is idle. Pulsing `start` launches a run from address zero. The run ends when a halt instruction executes. The architectural results match those of a single-cycle cell with combinational memories, instruction for instruction. The cell simply takes three clocks per instruction.

Top module: `cell_sync_mac`

## Requirements
- R1: After reset, busy, halted, pc and acc are all zero and phase is 0 (fetch). The general registers are zero.
- R2: While busy, phase steps one value per clock in the order 0 (fetch), 1 (read), 2 (execute), then back to 0. Each instruction begins in phase 0 and no other phase value appears.
- R3: In phases 0 and 1, pc, acc, the pointers, the registers and data memory keep their values. Only the execute clock changes them.
- R4: While busy is low and start is low, phase, pc and acc hold. A start pulse that arrives while busy is high has no effect on the run.
- R5: When start is high and busy is low, the next clock sets busy, clears halted, sets pc to 0 and sets phase to 0.
- R6: Opcode 0 (halt) sets halted, clears busy and leaves pc at the halt address. A run of n executed instructions, the halt included, keeps busy high for exactly 3·n clocks.
- R7: Instructions are 32 bits wide: opcode [31:28], rd [27:24], ra [23:20], rb [19:16] and a signed immediate [15:0]. Opcode 5 writes the sign-extended immediate to rd. Opcode 1 adds the product of the signed low 32 bits of ra and rb to the 64-bit accumulator. Opcode 3 clears the accumulator. Opcode 4 copies the accumulator to rd. Every other opcode not listed here only advances pc.
- R8: Opcode 7 stores register rb to data word (ra mod 32). Opcode 6 loads data word (ra mod 32) into rd. A load that follows a store sees the stored value.
- R9: Opcodes 8 and 9 load the weight pointer and the stream pointer from imm[4:0]. Opcode 2 adds the signed product of weight[wptr] and stream[sptr] to the accumulator, then increments both pointers, wrapping from 31 to 0.
- R10: Opcode 10 sets pc to pc+imm (modulo 64) when register ra, taken as signed, is zero or negative. Otherwise pc advances by one.
- R11: The debug port returns the selected word combinationally. Select codes are 0 = program, 1 = data, 2 = weight, 3 = stream, 4 = register. A debug write to memory takes effect only while busy is low and is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run from address 0 when idle |
| dbg_sel | input | 3 | Debug target select (0 program, 1 data, 2 weight, 3 stream, 4 register) |
| dbg_addr | input | 6 | Debug word address |
| dbg_we | input | 1 | Debug write strobe, honoured only while idle |
| dbg_wdata | input | 64 | Debug write data (low 32 bits for 32-bit memories) |
| dbg_rdata | output | 64 | Combinational debug read data |
| busy | output | 1 | A run is in progress |
| halted | output | 1 | The last run ended on a halt |
| phase | output | 2 | Current phase: 0 fetch, 1 read, 2 execute |
| pc | output | 6 | Program counter |
| acc | output | 64 | Accumulator |

## Verification
Two events can share a single clock: an execute-phase store to data memory and a host write strobe aimed at the same data word. The bench provokes this by holding the debug write strobe high on the store's target address for a whole run, and it also pulses start in mid-run. The result is judged after the halt. The word must hold the stored accumulator value, not the host value, and the clock count and phase trace of the run must be unchanged.

// File: rtl/cell_pkg.sv
package cell_pkg;

    localparam int XLEN   = 64;
    localparam int EW     = XLEN / 2;
    localparam int ILEN   = 32;
    localparam int IMM_W  = 16;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_READ  = 2'd1,
        PH_EXEC  = 2'd2
    } phase_e;

    typedef enum logic [3:0] {
        OP_HALT   = 4'd0,
        OP_MAC    = 4'd1,
        OP_KMAC   = 4'd2,
        OP_CLRACC = 4'd3,
        OP_MOVACC = 4'd4,
        OP_LI     = 4'd5,
        OP_LD     = 4'd6,
        OP_ST     = 4'd7,
        OP_SETW   = 4'd8,
        OP_SETS   = 4'd9,
        OP_BLZ    = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        SEL_PROG = 3'd0,
        SEL_DATA = 3'd1,
        SEL_WGT  = 3'd2,
        SEL_STRM = 3'd3,
        SEL_REG  = 3'd4
    } dbg_sel_e;

    typedef struct packed {
        logic [3:0]       op;
        logic [3:0]       rd;
        logic [3:0]       ra;
        logic [3:0]       rb;
        logic [IMM_W-1:0] imm;
    } instr_t;

    typedef logic [NREG-1:0][XLEN-1:0] regfile_t;

endpackage

// File: rtl/cell_sram_sync.sv
module cell_sram_sync #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data_q,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // registered read: this register doubles as the consumer's latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= mem[rd_addr];
        end
    end

    assign peek_data = mem[peek_addr];

endmodule

// File: rtl/cell_exec.sv
module cell_exec
    import cell_pkg::*;
#(
    parameter int PC_W    = 6,
    parameter int LOC_AW  = 5,
    parameter int DATA_AW = 5
) (
    input  instr_t              ir,
    input  logic [XLEN-1:0]     ld_word,
    input  logic [EW-1:0]       w_elem,
    input  logic [EW-1:0]       s_elem,
    input  regfile_t            regs,
    input  logic [XLEN-1:0]     acc,
    input  logic [PC_W-1:0]     pc,
    input  logic [LOC_AW-1:0]   wptr,
    input  logic [LOC_AW-1:0]   sptr,
    output logic [PC_W-1:0]     pc_n,
    output logic [XLEN-1:0]     acc_n,
    output logic [LOC_AW-1:0]   wptr_n,
    output logic [LOC_AW-1:0]   sptr_n,
    output logic                rf_we,
    output logic [RIDX_W-1:0]   rf_idx,
    output logic [XLEN-1:0]     rf_val,
    output logic                dm_we,
    output logic [DATA_AW-1:0]  dm_addr,
    output logic [XLEN-1:0]     dm_val,
    output logic                halt_n
);

    function automatic logic [XLEN-1:0] smul(input logic [EW-1:0] a, input logic [EW-1:0] b);
        logic signed [XLEN-1:0] ea;
        logic signed [XLEN-1:0] eb;
        ea = {{(XLEN-EW){a[EW-1]}}, a};
        eb = {{(XLEN-EW){b[EW-1]}}, b};
        return ea * eb;
    endfunction

    logic [XLEN-1:0] reg_a;
    logic [XLEN-1:0] reg_b;
    logic [XLEN-1:0] imm_ext;

    assign reg_a   = regs[ir.ra];
    assign reg_b   = regs[ir.rb];
    assign imm_ext = {{(XLEN-IMM_W){ir.imm[IMM_W-1]}}, ir.imm};

    always_comb begin
        pc_n    = pc + PC_W'(1);
        acc_n   = acc;
        wptr_n  = wptr;
        sptr_n  = sptr;
        rf_we   = 1'b0;
        rf_idx  = ir.rd;
        rf_val  = '0;
        dm_we   = 1'b0;
        dm_addr = reg_a[DATA_AW-1:0];
        dm_val  = reg_b;
        halt_n  = 1'b0;
        case (op_e'(ir.op))
            OP_HALT: begin
                pc_n   = pc;
                halt_n = 1'b1;
            end
            OP_MAC:    acc_n = acc + smul(reg_a[EW-1:0], reg_b[EW-1:0]);
            OP_KMAC: begin
                acc_n  = acc + smul(w_elem, s_elem);
                wptr_n = wptr + LOC_AW'(1);
                sptr_n = sptr + LOC_AW'(1);
            end
            OP_CLRACC: acc_n = '0;
            OP_MOVACC: begin
                rf_we  = 1'b1;
                rf_val = acc;
            end
            OP_LI: begin
                rf_we  = 1'b1;
                rf_val = imm_ext;
            end
            OP_LD: begin
                rf_we  = 1'b1;
                rf_val = ld_word;
            end
            OP_ST:     dm_we  = 1'b1;
            OP_SETW:   wptr_n = ir.imm[LOC_AW-1:0];
            OP_SETS:   sptr_n = ir.imm[LOC_AW-1:0];
            OP_BLZ: begin
                if ($signed(reg_a) <= 0) begin
                    pc_n = pc + ir.imm[PC_W-1:0];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cell_sync_mac.sv
module cell_sync_mac
    import cell_pkg::*;
#(
    parameter int PROG_DEPTH = 64,
    parameter int DATA_DEPTH = 32,
    parameter int LOC_DEPTH  = 32,
    localparam int PC_W      = $clog2(PROG_DEPTH),
    localparam int DATA_AW   = $clog2(DATA_DEPTH),
    localparam int LOC_AW    = $clog2(LOC_DEPTH),
    localparam int DBG_AW    = (PC_W > DATA_AW) ? ((PC_W > LOC_AW) ? PC_W : LOC_AW)
                                                : ((DATA_AW > LOC_AW) ? DATA_AW : LOC_AW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        dbg_sel,
    input  logic [DBG_AW-1:0] dbg_addr,
    input  logic              dbg_we,
    input  logic [XLEN-1:0]   dbg_wdata,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic              busy,
    output logic              halted,
    output logic [1:0]        phase,
    output logic [PC_W-1:0]   pc,
    output logic [XLEN-1:0]   acc
);

    typedef struct packed {
        phase_e            phase;
        logic              busy;
        logic              halted;
        logic [PC_W-1:0]   pc;
        logic [XLEN-1:0]   acc;
        logic [LOC_AW-1:0] wptr;
        logic [LOC_AW-1:0] sptr;
        regfile_t          regs;
    } state_t;

    state_t st_d, st_q;

    // memory read data = instruction and operand latches
    logic [ILEN-1:0] prog_q;
    logic [XLEN-1:0] data_q;
    logic [EW-1:0]   wgt_q;
    logic [EW-1:0]   strm_q;
    instr_t          ir;
    assign ir = instr_t'(prog_q);

    logic [ILEN-1:0] prog_peek;
    logic [XLEN-1:0] data_peek;
    logic [EW-1:0]   wgt_peek;
    logic [EW-1:0]   strm_peek;

    logic prog_re, opnd_re;
    logic host_wr;
    logic in_exec;

    logic [PC_W-1:0]    ex_pc_n;
    logic [XLEN-1:0]    ex_acc_n;
    logic [LOC_AW-1:0]  ex_wptr_n, ex_sptr_n;
    logic               ex_rf_we;
    logic [RIDX_W-1:0]  ex_rf_idx;
    logic [XLEN-1:0]    ex_rf_val;
    logic               ex_dm_we;
    logic [DATA_AW-1:0] ex_dm_addr;
    logic [XLEN-1:0]    ex_dm_val;
    logic               ex_halt;

    logic               dm_we;
    logic [DATA_AW-1:0] dm_waddr;
    logic [XLEN-1:0]    dm_wdata;
    logic [XLEN-1:0]    opnd_reg;

    assign host_wr  = dbg_we && !st_q.busy;
    assign in_exec  = st_q.busy && !st_q.halted && (st_q.phase == PH_EXEC);
    assign opnd_reg = st_q.regs[ir.ra];

    cell_exec #(
        .PC_W   (PC_W),
        .LOC_AW (LOC_AW),
        .DATA_AW(DATA_AW)
    ) u_exec (
        .ir      (ir),
        .ld_word (data_q),
        .w_elem  (wgt_q),
        .s_elem  (strm_q),
        .regs    (st_q.regs),
        .acc     (st_q.acc),
        .pc      (st_q.pc),
        .wptr    (st_q.wptr),
        .sptr    (st_q.sptr),
        .pc_n    (ex_pc_n),
        .acc_n   (ex_acc_n),
        .wptr_n  (ex_wptr_n),
        .sptr_n  (ex_sptr_n),
        .rf_we   (ex_rf_we),
        .rf_idx  (ex_rf_idx),
        .rf_val  (ex_rf_val),
        .dm_we   (ex_dm_we),
        .dm_addr (ex_dm_addr),
        .dm_val  (ex_dm_val),
        .halt_n  (ex_halt)
    );

    // phase controller and architectural state
    always_comb begin
        st_d    = st_q;
        prog_re = 1'b0;
        opnd_re = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.halted = 1'b0;
                st_d.pc     = '0;
                st_d.phase  = PH_FETCH;
            end
        end else if (!st_q.halted) begin
            case (st_q.phase)
                PH_FETCH: begin
                    prog_re    = 1'b1;
                    st_d.phase = PH_READ;
                end
                PH_READ: begin
                    opnd_re    = 1'b1;
                    st_d.phase = PH_EXEC;
                end
                PH_EXEC: begin
                    st_d.pc     = ex_pc_n;
                    st_d.acc    = ex_acc_n;
                    st_d.wptr   = ex_wptr_n;
                    st_d.sptr   = ex_sptr_n;
                    if (ex_rf_we) begin
                        st_d.regs[ex_rf_idx] = ex_rf_val;
                    end
                    st_d.halted = ex_halt;
                    st_d.busy   = !ex_halt;
                    st_d.phase  = PH_FETCH;
                end
                default: st_d.phase = PH_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // data memory write: execute store, or host while idle
    always_comb begin
        dm_we    = 1'b0;
        dm_waddr = ex_dm_addr;
        dm_wdata = ex_dm_val;
        if (in_exec && ex_dm_we) begin
            dm_we = 1'b1;
        end else if (host_wr && dbg_sel == SEL_DATA) begin
            dm_we    = 1'b1;
            dm_waddr = dbg_addr[DATA_AW-1:0];
            dm_wdata = dbg_wdata;
        end
    end

    cell_sram_sync #(.W(ILEN), .DEPTH(PROG_DEPTH)) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (prog_re),
        .rd_addr   (st_q.pc),
        .rd_data_q (prog_q),
        .wr_en     (host_wr && dbg_sel == SEL_PROG),
        .wr_addr   (dbg_addr[PC_W-1:0]),
        .wr_data   (dbg_wdata[ILEN-1:0]),
        .peek_addr (dbg_addr[PC_W-1:0]),
        .peek_data (prog_peek)
    );

    cell_sram_sync #(.W(XLEN), .DEPTH(DATA_DEPTH)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (opnd_re),
        .rd_addr   (opnd_reg[DATA_AW-1:0]),
        .rd_data_q (data_q),
        .wr_en     (dm_we),
        .wr_addr   (dm_waddr),
        .wr_data   (dm_wdata),
        .peek_addr (dbg_addr[DATA_AW-1:0]),
        .peek_data (data_peek)
    );

    cell_sram_sync #(.W(EW), .DEPTH(LOC_DEPTH)) u_wgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (opnd_re),
        .rd_addr   (st_q.wptr),
        .rd_data_q (wgt_q),
        .wr_en     (host_wr && dbg_sel == SEL_WGT),
        .wr_addr   (dbg_addr[LOC_AW-1:0]),
        .wr_data   (dbg_wdata[EW-1:0]),
        .peek_addr (dbg_addr[LOC_AW-1:0]),
        .peek_data (wgt_peek)
    );

    cell_sram_sync #(.W(EW), .DEPTH(LOC_DEPTH)) u_strm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (opnd_re),
        .rd_addr   (st_q.sptr),
        .rd_data_q (strm_q),
        .wr_en     (host_wr && dbg_sel == SEL_STRM),
        .wr_addr   (dbg_addr[LOC_AW-1:0]),
        .wr_data   (dbg_wdata[EW-1:0]),
        .peek_addr (dbg_addr[LOC_AW-1:0]),
        .peek_data (strm_peek)
    );

    // combinational debug read
    always_comb begin
        case (dbg_sel)
            SEL_PROG: dbg_rdata = {{(XLEN-ILEN){1'b0}}, prog_peek};
            SEL_DATA: dbg_rdata = data_peek;
            SEL_WGT:  dbg_rdata = {{(XLEN-EW){1'b0}}, wgt_peek};
            SEL_STRM: dbg_rdata = {{(XLEN-EW){1'b0}}, strm_peek};
            SEL_REG:  dbg_rdata = st_q.regs[dbg_addr[RIDX_W-1:0]];
            default:  dbg_rdata = '0;
        endcase
    end

    assign busy   = st_q.busy;
    assign halted = st_q.halted;
    assign phase  = st_q.phase;
    assign pc     = st_q.pc;
    assign acc    = st_q.acc;

endmodule

// File: rtl/cell_sync_mac_chk.sv
module cell_sync_mac_chk
    import cell_pkg::*;
#(
    parameter int PC_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            halted,
    input logic [1:0]      phase,
    input logic [PC_W-1:0] pc,
    input logic [XLEN-1:0] acc
);

    // R2
    phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    // R2
    fetch_to_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase == 2'd0 |=> busy && phase == 2'd1);

    // R2
    read_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase == 2'd1 |=> busy && phase == 2'd2);

    // R2
    exec_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase == 2'd2 |=> phase == 2'd0);

    // R3
    no_early_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase != 2'd2 |=> $stable(pc) && $stable(acc));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !busy && $stable(phase) && $stable(pc) && $stable(acc));

    // R5
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && !halted && phase == 2'd0 && pc == '0);

    // R6
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !busy);

endmodule

bind cell_sync_mac cell_sync_mac_chk #(.PC_W($clog2(PROG_DEPTH))) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .halted(halted),
    .phase (phase),
    .pc    (pc),
    .acc   (acc)
);

// File: tb/cell_sync_mac_test.sv
module cell_sync_mac_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  dbg_sel = 3'd0;
    logic [5:0]  dbg_addr = 6'd0;
    logic        dbg_we = 1'b0;
    logic [63:0] dbg_wdata = 64'd0;
    logic [63:0] dbg_rdata;
    logic        busy, halted;
    logic [1:0]  phase;
    logic [5:0]  pc;
    logic [63:0] acc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] wmem [32];
    logic [31:0] smem [32];

    always #10 clk = ~clk;

    cell_sync_mac uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dbg_sel(dbg_sel), .dbg_addr(dbg_addr), .dbg_we(dbg_we),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .busy(busy), .halted(halted), .phase(phase), .pc(pc), .acc(acc)
    );

    function automatic logic [31:0] enc(input int op, input int rd, input int ra,
                                        input int rb, input int imm);
        return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm[15:0]};
    endfunction

    function automatic logic [63:0] sext16(input logic [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    function automatic logic [63:0] prod(input logic [31:0] a, input logic [31:0] b);
        longint ea, eb;
        ea = longint'($signed(a));
        eb = longint'($signed(b));
        return 64'(ea * eb);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int sel, input int addr, input logic [63:0] data);
        @(negedge clk);
        dbg_sel   = sel[2:0];
        dbg_addr  = addr[5:0];
        dbg_wdata = data;
        dbg_we    = 1'b1;
        @(negedge clk);
        dbg_we    = 1'b0;
    endtask

    task automatic host_rd(input int sel, input int addr, output logic [63:0] data);
        @(negedge clk);
        dbg_sel  = sel[2:0];
        dbg_addr = addr[5:0];
        #1;
        data = dbg_rdata;
    endtask

    // Launch a run and count the clocks busy stays high. With disturb set, a
    // host write to data word 7 is held throughout and start is pulsed mid-run.
    task automatic run_prog(input bit disturb, output int cyc);
        int bad;
        logic [1:0] prev_ph;
        logic [5:0] prev_pc;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R5: launch state
        chk("R5 launch", {busy, halted, phase, pc}, {1'b1, 1'b0, 2'd0, 6'd0});
        if (disturb) begin
            dbg_sel   = 3'd1;
            dbg_addr  = 6'd7;
            dbg_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
            dbg_we    = 1'b1;
        end
        cyc = 0;
        bad = 0;
        prev_ph = 2'd0;
        prev_pc = pc;
        while (busy && cyc < 3000) begin
            if (int'(phase) != cyc % 3) bad++;
            if (cyc > 0 && prev_ph != 2'd2 && pc != prev_pc) bad++;
            if (disturb && cyc == 4) start = 1'b1;
            if (disturb && cyc == 5) start = 1'b0;
            prev_ph = phase;
            prev_pc = pc;
            cyc++;
            @(negedge clk);
        end
        dbg_we = 1'b0;
        start  = 1'b0;
        // R2 and R3: phase order and pc moving only after execute
        chk("R2/R3 phase trace", 64'(bad), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected halt");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv;
        logic [63:0] exp_acc;
        int cyc;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", {busy, halted, phase, pc}, 64'd0);
        chk("R1 acc", acc, 64'd0);
        host_rd(4, 5, rv);
        chk("R1 register", rv, 64'd0);

        for (int i = 0; i < 32; i++) begin
            wmem[i] = $urandom;
            smem[i] = $urandom;
            host_wr(2, i, {32'd0, wmem[i]});
            host_wr(3, i, {32'd0, smem[i]});
        end
        // R11: combinational debug read
        host_rd(2, 3, rv);
        chk("R11 weight peek", rv, {32'd0, wmem[3]});
        host_rd(3, 31, rv);
        chk("R11 stream peek", rv, {32'd0, smem[31]});

        // Program A: arithmetic, pointer MAC, store/load
        for (int it = 0; it < 3; it++) begin
            logic [15:0] a, b;
            a = (it == 0) ? 16'h8000 : 16'($urandom);
            b = (it == 0) ? 16'h7FFF : 16'($urandom);
            host_wr(0, 0,  {32'd0, enc(5, 1, 0, 0, int'(a))});
            host_wr(0, 1,  {32'd0, enc(5, 2, 0, 0, int'(b))});
            host_wr(0, 2,  {32'd0, enc(3, 0, 0, 0, 0)});
            host_wr(0, 3,  {32'd0, enc(1, 0, 1, 2, 0)});
            host_wr(0, 4,  {32'd0, enc(8, 0, 0, 0, 3)});
            host_wr(0, 5,  {32'd0, enc(9, 0, 0, 0, 5)});
            host_wr(0, 6,  {32'd0, enc(2, 0, 0, 0, 0)});
            host_wr(0, 7,  {32'd0, enc(2, 0, 0, 0, 0)});
            host_wr(0, 8,  {32'd0, enc(4, 3, 0, 0, 0)});
            host_wr(0, 9,  {32'd0, enc(5, 4, 0, 0, 7)});
            host_wr(0, 10, {32'd0, enc(7, 0, 4, 3, 0)});
            host_wr(0, 11, {32'd0, enc(6, 5, 4, 0, 0)});
            host_wr(0, 12, {32'd0, enc(0, 0, 0, 0, 0)});
            run_prog(it == 0, cyc);
            exp_acc = prod(sext16(a), sext16(b)) + prod(wmem[3], smem[5]) + prod(wmem[4], smem[6]);
            // R6: 13 instructions take 39 clocks; pc stays on the halt
            chk("R6 clock count", 64'(cyc), 64'd39);
            chk("R6 halt status", {busy, halted, pc}, {1'b0, 1'b1, 6'd12});
            host_rd(4, 1, rv);
            chk("R7 li r1", rv, sext16(a));
            host_rd(4, 2, rv);
            chk("R7 li r2", rv, sext16(b));
            // R7 mac plus R9 pointer mac
            chk("R7/R9 acc", acc, exp_acc);
            host_rd(4, 3, rv);
            chk("R7 movacc", rv, exp_acc);
            // R8 and R11: the store beats the host write held on word 7
            host_rd(1, 7, rv);
            chk("R8/R11 stored word", rv, exp_acc);
            host_rd(4, 5, rv);
            chk("R8 load after store", rv, exp_acc);
        end

        // R4: idle cell holds
        repeat (10) @(negedge clk);
        chk("R4 idle hold", {busy, halted, phase, pc}, {1'b0, 1'b1, 2'd0, 6'd12});
        chk("R4 idle acc", acc, exp_acc);
        // R11: host write lands when idle
        host_wr(1, 9, 64'h0123_4567_89AB_CDEF);
        host_rd(1, 9, rv);
        chk("R11 idle write", rv, 64'h0123_4567_89AB_CDEF);

        // Program B: branches
        host_wr(0, 0, {32'd0, enc(5, 1, 0, 0, 0)});
        host_wr(0, 1, {32'd0, enc(10, 0, 1, 0, 2)});
        host_wr(0, 2, {32'd0, enc(5, 7, 0, 0, 99)});
        host_wr(0, 3, {32'd0, enc(5, 1, 0, 0, 5)});
        host_wr(0, 4, {32'd0, enc(10, 0, 1, 0, 2)});
        host_wr(0, 5, {32'd0, enc(5, 8, 0, 0, 42)});
        host_wr(0, 6, {32'd0, enc(5, 9, 0, 0, -3)});
        host_wr(0, 7, {32'd0, enc(10, 0, 9, 0, 2)});
        host_wr(0, 8, {32'd0, enc(5, 10, 0, 0, 1)});
        host_wr(0, 9, {32'd0, enc(0, 0, 0, 0, 0)});
        run_prog(1'b0, cyc);
        // R6: eight executed instructions
        chk("R6 branch clock count", 64'(cyc), 64'd24);
        chk("R10 final pc", 64'(pc), 64'd9);
        host_rd(4, 7, rv);
        chk("R10 zero taken", rv, 64'd0);
        host_rd(4, 8, rv);
        chk("R10 positive not taken", rv, 64'd42);
        host_rd(4, 10, rv);
        chk("R10 negative taken", rv, 64'd0);

        // Program C: pointer MAC runs, first one across the wrap
        for (int it = 0; it < 6; it++) begin
            int p, q;
            p = (it == 0) ? 30 : $urandom_range(0, 31);
            q = (it == 0) ? 31 : $urandom_range(0, 31);
            host_wr(0, 0, {32'd0, enc(8, 0, 0, 0, p)});
            host_wr(0, 1, {32'd0, enc(9, 0, 0, 0, q)});
            host_wr(0, 2, {32'd0, enc(3, 0, 0, 0, 0)});
            host_wr(0, 3, {32'd0, enc(2, 0, 0, 0, 0)});
            host_wr(0, 4, {32'd0, enc(2, 0, 0, 0, 0)});
            host_wr(0, 5, {32'd0, enc(2, 0, 0, 0, 0)});
            host_wr(0, 6, {32'd0, enc(4, 11, 0, 0, 0)});
            host_wr(0, 7, {32'd0, enc(0, 0, 0, 0, 0)});
            run_prog(1'b0, cyc);
            exp_acc = '0;
            for (int k = 0; k < 3; k++) begin
                exp_acc = exp_acc + prod(wmem[(p + k) % 32], smem[(q + k) % 32]);
            end
            chk("R6 kmac clock count", 64'(cyc), 64'd24);
            chk("R9 kmac acc", acc, exp_acc);
            host_rd(4, 11, rv);
            chk("R9 kmac copy", rv, exp_acc);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule